// File: doc/BRIEF.md
# Operand Effective Address Sequencer

This block turns an addressing-mode code and the address of an instruction's first operand byte into a 16-bit effective address. Where the mode calls for it, the block also returns the data byte found at that address. It does this over a single byte-wide read port into memory. For each mode it walks a fixed sequence of steps: it fetches one or two operand bytes, adds an index register, follows a little-endian pointer through one or two levels, or forms a branch target relative to the next instruction. It also reports where the next instruction begins.

A raw-operand input stops every dereferencing read. With it set, pointer modes report the operand address as fetched, and no data byte is read. A code listing tool can use this to show operands without touching the memory they point to. Opcode decode and execution belong to the surrounding logic.

The memory read port is registered. A byte requested with the read enable in one cycle is presented on the data input in the next cycle. A request is taken while the block is idle or in the cycle that reports a result. All inputs are captured in that cycle.

Top module: `eaddr_walker`

## Requirements
- R1: Mode codes 0 (implied) and 1 (accumulator) issue no read and report address 0, data 0 and a next-instruction address equal to the input address.
- R2: Mode 2 (immediate) reads one byte at the input address. It reports that address as the effective address and that byte as the data. The next-instruction address is the input address plus 1.
- R3: Modes 3, 4 and 5 (page-zero, plus X, plus Y) read one byte B. The address is 0x00 in the high byte and (B + index) mod 256 in the low byte. Data is the byte at that address, and the next-instruction address is the input address plus 1.
- R4: Modes 6, 7 and 8 (absolute, plus X, plus Y) read a low byte then a high byte from consecutive addresses. The index is added with 16-bit wrap. Data is read at the result, and the next-instruction address is the input address plus 2.
- R5: Mode 9 (relative) reads one signed byte D. The address is input address + 1 + D, with 16-bit wrap. Data is 0 and the next-instruction address is the input address plus 1.
- R6: Mode 10 (indirect) reads a 16-bit pointer P. The address's low byte is read from P and its high byte from P+1, with 16-bit wrap. Data is read at the result, and the next-instruction address is the input address plus 2.
- R7: Mode 11 (indexed pointer) reads byte B and forms Q = (B + X) mod 256. The address's low byte comes from page-zero Q and its high byte from page-zero (Q+1) mod 256. Data is read at the result, and the next-instruction address is the input address plus 1.
- R8: Mode 12 (pointer then index) reads byte B. The pointer's low byte comes from page-zero B and its high byte from page-zero (B+1) mod 256. Y is added with 16-bit wrap. Data is read at the result, and the next-instruction address is the input address plus 1.
- R9: With raw-operand set, no data or pointer dereference is read and data reports 0, except in mode 2. Modes 10, 11 and 12 report the fetched operand address: the 16-bit pointer, or 0x00 followed by B. Index modes still add their index. The next-instruction address is unchanged.
- R10: Mode codes 13 to 15 give a one-cycle error pulse with no done pulse and no read.
- R11: Each accepted request gives exactly one done pulse, and the busy output is high while the request is in progress. A request raised while busy is ignored.
- R12: A request raised in the same cycle as a done pulse is accepted and completes correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request strobe |
| mode_i | input | 4 | Addressing-mode code |
| raw_i | input | 1 | Suppress dereferencing reads |
| pc_i | input | 16 | Address of first operand byte |
| xr_i | input | 8 | X index value |
| yr_i | input | 8 | Y index value |
| rd_en_o | output | 1 | Memory read enable |
| rd_addr_o | output | 16 | Memory read address |
| rd_data_i | input | 8 | Read data, one cycle after the request |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle result strobe |
| err_o | output | 1 | One-cycle unknown-mode strobe |
| ea_o | output | 16 | Effective address |
| operand_o | output | 8 | Data byte at the effective address |
| pc_next_o | output | 16 | Address of the next instruction |

## Verification
A result report and the acceptance of the next request can fall in the same cycle, because the done state also accepts a request. The bench provokes this by chaining operations with the next start driven in the very cycle that done is observed, across every mode code. Each chained result is compared against the arithmetic model, and so are its read count and next-instruction address, exactly as for operations that are separated by an idle cycle. A start raised in the middle of a busy sequence is also injected, and the bench confirms that it produces no second result.

// File: rtl/eaw_pkg.sv
package eaw_pkg;

  localparam int unsigned MODE_W = 4;

  localparam logic [MODE_W-1:0] MD_IMPL = 4'd0;
  localparam logic [MODE_W-1:0] MD_ACCU = 4'd1;
  localparam logic [MODE_W-1:0] MD_IMMD = 4'd2;
  localparam logic [MODE_W-1:0] MD_ZPG  = 4'd3;
  localparam logic [MODE_W-1:0] MD_ZPGX = 4'd4;
  localparam logic [MODE_W-1:0] MD_ZPGY = 4'd5;
  localparam logic [MODE_W-1:0] MD_ABSL = 4'd6;
  localparam logic [MODE_W-1:0] MD_ABSX = 4'd7;
  localparam logic [MODE_W-1:0] MD_ABSY = 4'd8;
  localparam logic [MODE_W-1:0] MD_RELB = 4'd9;
  localparam logic [MODE_W-1:0] MD_INDR = 4'd10;
  localparam logic [MODE_W-1:0] MD_IDXI = 4'd11;
  localparam logic [MODE_W-1:0] MD_INDY = 4'd12;

  typedef enum logic [1:0] {IX_NONE, IX_X, IX_Y} idx_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_F0, ST_F1, ST_C0, ST_C1, ST_P0, ST_P1, ST_P2,
    ST_DATA, ST_DW, ST_FIN, ST_ERR
  } st_e;

  typedef struct packed {
    logic       legal;
    logic [1:0] nbytes;
    logic       word;
    logic       zptr;
    logic       indr;
    logic       rel;
    logic       imm;
    idx_e       idx;
  } mode_info_t;

endpackage

// File: rtl/eaw_mode_dec.sv
module eaw_mode_dec
  import eaw_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  output mode_info_t        info
);

  always_comb begin
    info = '{legal: 1'b1, nbytes: 2'd0, word: 1'b0, zptr: 1'b0,
             indr: 1'b0, rel: 1'b0, imm: 1'b0, idx: IX_NONE};
    case (mode)
      MD_IMPL, MD_ACCU: info.nbytes = 2'd0;
      MD_IMMD: begin info.nbytes = 2'd1; info.imm = 1'b1; end
      MD_ZPG:  info.nbytes = 2'd1;
      MD_ZPGX: begin info.nbytes = 2'd1; info.idx = IX_X; end
      MD_ZPGY: begin info.nbytes = 2'd1; info.idx = IX_Y; end
      MD_ABSL: begin info.nbytes = 2'd2; info.word = 1'b1; end
      MD_ABSX: begin info.nbytes = 2'd2; info.word = 1'b1; info.idx = IX_X; end
      MD_ABSY: begin info.nbytes = 2'd2; info.word = 1'b1; info.idx = IX_Y; end
      MD_RELB: begin info.nbytes = 2'd1; info.rel = 1'b1; end
      MD_INDR: begin info.nbytes = 2'd2; info.word = 1'b1; info.indr = 1'b1; end
      MD_IDXI: begin info.nbytes = 2'd1; info.zptr = 1'b1; info.idx = IX_X; end
      MD_INDY: begin info.nbytes = 2'd1; info.zptr = 1'b1; info.idx = IX_Y; end
      default: info.legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/eaw_addr_unit.sv
module eaw_addr_unit
  import eaw_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic [ADDR_W-1:0] pc_base,
  input  logic [DATA_W-1:0] lo,
  input  logic [DATA_W-1:0] hi,
  input  logic [DATA_W-1:0] xv,
  input  logic [DATA_W-1:0] yv,
  input  idx_e              idx,
  output logic [ADDR_W-1:0] zp_raw,
  output logic [ADDR_W-1:0] zp_sum,
  output logic [ADDR_W-1:0] word_raw,
  output logic [ADDR_W-1:0] word_sum,
  output logic [ADDR_W-1:0] rel_tgt
);

  localparam int PAGE_W = ADDR_W - DATA_W;

  logic [DATA_W-1:0] idx_val;
  logic [DATA_W-1:0] zp_low;

  always_comb begin
    case (idx)
      IX_X:    idx_val = xv;
      IX_Y:    idx_val = yv;
      default: idx_val = '0;
    endcase
  end

  // page-zero arithmetic wraps inside the low byte
  assign zp_low   = lo + idx_val;
  assign zp_raw   = {{PAGE_W{1'b0}}, lo};
  assign zp_sum   = {{PAGE_W{1'b0}}, zp_low};
  assign word_raw = {hi, lo};
  assign word_sum = word_raw + {{PAGE_W{1'b0}}, idx_val};
  assign rel_tgt  = pc_base + ADDR_W'(1) + {{PAGE_W{lo[DATA_W-1]}}, lo};

endmodule

// File: rtl/eaddr_walker.sv
module eaddr_walker
  import eaw_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [MODE_W-1:0]   mode_i,
  input  logic                raw_i,
  input  logic [ADDR_W-1:0]   pc_i,
  input  logic [DATA_W-1:0]   xr_i,
  input  logic [DATA_W-1:0]   yr_i,
  output logic                rd_en_o,
  output logic [ADDR_W-1:0]   rd_addr_o,
  input  logic [DATA_W-1:0]   rd_data_i,
  output logic                busy_o,
  output logic                done_o,
  output logic                err_o,
  output logic [ADDR_W-1:0]   ea_o,
  output logic [DATA_W-1:0]   operand_o,
  output logic [ADDR_W-1:0]   pc_next_o
);

  localparam int PAGE_W = ADDR_W - DATA_W;

  // reset: asynchronous assertion, synchronous release
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  st_e               state_q, state_d;
  mode_info_t        info_q, info_d, dec_info;
  logic [MODE_W-1:0] mode_q, mode_d;
  logic              raw_q, raw_d;
  logic [ADDR_W-1:0] pcb_q, pcb_d;
  logic [DATA_W-1:0] x_q, x_d, y_q, y_d, b0_q, b0_d, opnd_q, opnd_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d, ea_q, ea_d, pcn_q, pcn_d;
  logic [ADDR_W-1:0] ptr_next;
  logic [DATA_W-1:0] lo_sel;
  logic [ADDR_W-1:0] zp_raw, zp_sum, word_raw, word_sum, rel_tgt;
  logic              ready;

  eaw_mode_dec u_dec (
    .mode (mode_i),
    .info (dec_info)
  );

  assign lo_sel = (state_q == ST_C0) ? rd_data_i : b0_q;

  eaw_addr_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_addr (
    .pc_base  (pcb_q),
    .lo       (lo_sel),
    .hi       (rd_data_i),
    .xv       (x_q),
    .yv       (y_q),
    .idx      (info_q.idx),
    .zp_raw   (zp_raw),
    .zp_sum   (zp_sum),
    .word_raw (word_raw),
    .word_sum (word_sum),
    .rel_tgt  (rel_tgt)
  );

  // second pointer byte: page-zero pointers wrap within page zero
  assign ptr_next = info_q.zptr
                  ? {ptr_q[ADDR_W-1:DATA_W], ptr_q[DATA_W-1:0] + DATA_W'(1)}
                  : ptr_q + ADDR_W'(1);

  assign ready = (state_q == ST_IDLE) || (state_q == ST_FIN) || (state_q == ST_ERR);

  always_comb begin
    state_d   = state_q;
    info_d    = info_q;
    mode_d    = mode_q;
    raw_d     = raw_q;
    pcb_d     = pcb_q;
    x_d       = x_q;
    y_d       = y_q;
    b0_d      = b0_q;
    ptr_d     = ptr_q;
    ea_d      = ea_q;
    opnd_d    = opnd_q;
    pcn_d     = pcn_q;
    rd_en_o   = 1'b0;
    rd_addr_o = '0;
    case (state_q)
      ST_IDLE, ST_FIN, ST_ERR: begin
        if (start_i) begin
          info_d = dec_info;
          mode_d = mode_i;
          raw_d  = raw_i;
          pcb_d  = pc_i;
          x_d    = xr_i;
          y_d    = yr_i;
          ea_d   = '0;
          opnd_d = '0;
          pcn_d  = pc_i + ADDR_W'(dec_info.nbytes);
          if (!dec_info.legal)           state_d = ST_ERR;
          else if (dec_info.nbytes == 0) state_d = ST_FIN;
          else                           state_d = ST_F0;
        end else begin
          state_d = ST_IDLE;
        end
      end
      ST_F0: begin
        rd_en_o   = 1'b1;
        rd_addr_o = pcb_q;
        state_d   = info_q.word ? ST_F1 : ST_C0;
      end
      ST_F1: begin
        rd_en_o   = 1'b1;
        rd_addr_o = pcb_q + ADDR_W'(1);
        b0_d      = rd_data_i;
        state_d   = ST_C1;
      end
      ST_C0: begin
        b0_d = rd_data_i;
        if (info_q.imm) begin
          ea_d    = pcb_q;
          opnd_d  = rd_data_i;
          state_d = ST_FIN;
        end else if (info_q.rel) begin
          ea_d    = rel_tgt;
          state_d = ST_FIN;
        end else if (info_q.zptr) begin
          if (raw_q) begin
            ea_d    = zp_raw;
            state_d = ST_FIN;
          end else begin
            ptr_d   = (info_q.idx == IX_X) ? zp_sum : zp_raw;
            state_d = ST_P0;
          end
        end else begin
          ea_d    = zp_sum;
          state_d = raw_q ? ST_FIN : ST_DATA;
        end
      end
      ST_C1: begin
        if (info_q.indr) begin
          if (raw_q) begin
            ea_d    = word_raw;
            state_d = ST_FIN;
          end else begin
            ptr_d   = word_raw;
            state_d = ST_P0;
          end
        end else begin
          ea_d    = word_sum;
          state_d = raw_q ? ST_FIN : ST_DATA;
        end
      end
      ST_P0: begin
        rd_en_o   = 1'b1;
        rd_addr_o = ptr_q;
        state_d   = ST_P1;
      end
      ST_P1: begin
        rd_en_o   = 1'b1;
        rd_addr_o = ptr_next;
        b0_d      = rd_data_i;
        state_d   = ST_P2;
      end
      ST_P2: begin
        ea_d    = (info_q.idx == IX_Y) ? word_sum : word_raw;
        state_d = ST_DATA;
      end
      ST_DATA: begin
        rd_en_o   = 1'b1;
        rd_addr_o = ea_q;
        state_d   = ST_DW;
      end
      ST_DW: begin
        opnd_d  = rd_data_i;
        state_d = ST_FIN;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      info_q  <= '0;
      mode_q  <= '0;
      raw_q   <= 1'b0;
      pcb_q   <= '0;
      x_q     <= '0;
      y_q     <= '0;
      b0_q    <= '0;
      ptr_q   <= '0;
      ea_q    <= '0;
      opnd_q  <= '0;
      pcn_q   <= '0;
    end else begin
      state_q <= state_d;
      info_q  <= info_d;
      mode_q  <= mode_d;
      raw_q   <= raw_d;
      pcb_q   <= pcb_d;
      x_q     <= x_d;
      y_q     <= y_d;
      b0_q    <= b0_d;
      ptr_q   <= ptr_d;
      ea_q    <= ea_d;
      opnd_q  <= opnd_d;
      pcn_q   <= pcn_d;
    end
  end

  assign busy_o    = !ready;
  assign done_o    = (state_q == ST_FIN);
  assign err_o     = (state_q == ST_ERR);
  assign ea_o      = ea_q;
  assign operand_o = opnd_q;
  assign pc_next_o = pcn_q;

  // R1: no-operand modes report address zero and an unmoved PC
  a_r1_implied_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_o && (mode_q == MD_IMPL || mode_q == MD_ACCU) |-> (ea_o == '0) && (pc_next_o == pcb_q));

  // R4: next-instruction address steps by the operand length
  a_r4_pc_step: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_o |-> pc_next_o == pcb_q + ADDR_W'(info_q.nbytes));

  // R3: page-zero modes stay in page zero
  a_r3_page_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_o && (mode_q == MD_ZPG || mode_q == MD_ZPGX || mode_q == MD_ZPGY)
      |-> ea_o[ADDR_W-1:DATA_W] == {PAGE_W{1'b0}});

  // R9: raw operand mode returns no data byte
  a_r9_raw_no_data: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_o && raw_q && !info_q.imm |-> operand_o == '0);

  // R10: error only follows a request taken in a ready state, for an unknown code
  a_r10_err_source: assert property (@(posedge clk) disable iff (!rst_sync_n)
    err_o |-> !info_q.legal && $past(!busy_o) && !rd_en_o);

  // R11: memory is only read while a request is in progress
  a_r11_read_busy: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_en_o |-> busy_o);

endmodule

// File: tb/eaddr_walker_bench.sv
`timescale 1ns/1ps
module eaddr_walker_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [3:0]  mode;
  logic        raw;
  logic [15:0] pc;
  logic [7:0]  xr, yr;
  logic        rd_en;
  logic [15:0] rd_addr;
  logic [7:0]  rd_data;
  logic        busy, done, err;
  logic [15:0] ea, pcn;
  logic [7:0]  opnd;

  int nchk = 0;
  int nfail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  eaddr_walker u_eaddr_walker (
    .clk(clk), .rst_n(rst_n), .start_i(start), .mode_i(mode), .raw_i(raw),
    .pc_i(pc), .xr_i(xr), .yr_i(yr), .rd_en_o(rd_en), .rd_addr_o(rd_addr),
    .rd_data_i(rd_data), .busy_o(busy), .done_o(done), .err_o(err),
    .ea_o(ea), .operand_o(opnd), .pc_next_o(pcn)
  );

  function automatic logic [7:0] mb(input logic [15:0] a);
    return (a[7:0] * 8'd37) ^ a[15:8] ^ 8'h5A;
  endfunction

  always @(posedge clk) if (rd_en) rd_data <= mb(rd_addr);

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic model(input logic [3:0] m, input bit nd, input logic [15:0] p,
                       input logic [7:0] x, input logic [7:0] y,
                       output logic [15:0] e, output logic [7:0] o,
                       output logic [15:0] pn, output int rd, output bit er,
                       output string tag);
    logic [7:0]  b0, b1, q;
    logic [15:0] w;
    b0 = mb(p);
    b1 = mb(p + 16'd1);
    w  = {b1, b0};
    e = '0; o = '0; pn = p; rd = 0; er = 1'b0; tag = "R1";
    case (m)
      4'd0, 4'd1: begin e = '0; tag = "R1"; end
      4'd2: begin e = p; o = b0; pn = p + 16'd1; rd = 1; tag = "R2"; end
      4'd3, 4'd4, 4'd5: begin
        q = b0 + ((m == 4'd4) ? x : (m == 4'd5) ? y : 8'd0);
        e = {8'h00, q}; pn = p + 16'd1;
        rd = nd ? 1 : 2; o = nd ? 8'h00 : mb(e); tag = nd ? "R9" : "R3";
      end
      4'd6, 4'd7, 4'd8: begin
        e = w + {8'h00, ((m == 4'd7) ? x : (m == 4'd8) ? y : 8'd0)};
        pn = p + 16'd2; rd = nd ? 2 : 3; o = nd ? 8'h00 : mb(e); tag = nd ? "R9" : "R4";
      end
      4'd9: begin
        e = p + 16'd1 + {{8{b0[7]}}, b0}; pn = p + 16'd1; rd = 1; tag = "R5";
      end
      4'd10: begin
        pn = p + 16'd2;
        if (nd) begin e = w; rd = 2; tag = "R9"; end
        else begin e = {mb(w + 16'd1), mb(w)}; o = mb(e); rd = 5; tag = "R6"; end
      end
      4'd11: begin
        pn = p + 16'd1;
        if (nd) begin e = {8'h00, b0}; rd = 1; tag = "R9"; end
        else begin
          q = b0 + x;
          e = {mb({8'h00, q + 8'd1}), mb({8'h00, q})}; o = mb(e); rd = 4; tag = "R7";
        end
      end
      4'd12: begin
        pn = p + 16'd1;
        if (nd) begin e = {8'h00, b0}; rd = 1; tag = "R9"; end
        else begin
          e = {mb({8'h00, b0 + 8'd1}), mb({8'h00, b0})} + {8'h00, y};
          o = mb(e); rd = 4; tag = "R8";
        end
      end
      default: begin er = 1'b1; tag = "R10"; end
    endcase
  endtask

  task automatic launch(input logic [3:0] m, input bit nd, input logic [15:0] p,
                        input logic [7:0] x, input logic [7:0] y);
    mode = m; raw = nd; pc = p; xr = x; yr = y; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic collect(output bit dn, output bit er, output int rd,
                         output logic [15:0] e, output logic [7:0] o,
                         output logic [15:0] pn);
    dn = 1'b0; er = 1'b0; rd = 0; e = '0; o = '0; pn = '0;
    for (int i = 0; i < 40; i++) begin
      if (rd_en) rd++;
      if (done || err) begin
        dn = done; er = err; e = ea; o = opnd; pn = pcn;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic judge(input logic [3:0] m, input bit nd, input logic [15:0] p,
                       input logic [7:0] x, input logic [7:0] y, input string extra);
    logic [15:0] xe, xpn, ge, gpn;
    logic [7:0]  xo, go;
    int xrd, grd;
    bit xer, gdn, ger;
    string tag;
    model(m, nd, p, x, y, xe, xo, xpn, xrd, xer, tag);
    collect(gdn, ger, grd, ge, go, gpn);
    if (xer) begin
      chk(ger && !gdn, "R10", {extra, " err pulse"}, {gdn, ger}, 2'b01);
      chk(grd == 0, "R10", {extra, " reads"}, grd, 0);
    end else begin
      chk(gdn && !ger, tag, {extra, " done"}, {gdn, ger}, 2'b10);
      chk(ge == xe, tag, {extra, " ea"}, ge, xe);
      chk(go == xo, tag, {extra, " operand"}, go, xo);
      chk(gpn == xpn, tag, {extra, " pc_next"}, gpn, xpn);
      chk(grd == xrd, tag, {extra, " reads"}, grd, xrd);
    end
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000 && !finished) begin
        finished = 1'b1;
        nchk++; nfail++;
        $display("FAIL watchdog act=%0d exp=<150000", cyc);
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
      end
    end
  end

  initial begin
    logic [15:0] p;
    logic [7:0]  x, y;
    rst_n = 1'b0; start = 1'b0; mode = '0; raw = 1'b0; pc = '0; xr = '0; yr = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && !rd_en, "R11", "reset idle",
        {busy, done, err, rd_en}, 4'b0000);

    // separated sweep over every mode code, both raw settings
    for (int m = 0; m < 16; m++) begin
      for (int nd = 0; nd < 2; nd++) begin
        for (int k = 0; k < 24; k++) begin
          p = (k == 1) ? 16'hFFFE : (k == 2) ? 16'hFFFF : 16'(k * 16'h0B3D + m * 7);
          x = 8'(k * 29 + m);
          y = (k == 3) ? 8'hFF : 8'(k * 53 + 3);
          launch(4'(m), nd[0], p, x, y);
          judge(4'(m), nd[0], p, x, y, "sweep");
          @(negedge clk);
          chk(!done && !err, "R11", "single pulse", {done, err}, 2'b00);
        end
      end
    end

    // back-to-back: next start in the done cycle
    for (int m = 0; m < 16; m++) begin
      for (int k = 0; k < 6; k++) begin
        p = 16'(k * 16'h2F11 + m * 3);
        x = 8'(k * 71 + m);
        y = 8'(k * 13 + 200);
        launch(4'(m), k[0], p, x, y);
        judge(4'(m), k[0], p, x, y, "R12 chained");
      end
    end
    @(negedge clk);

    // start while busy is ignored
    launch(4'd7, 1'b0, 16'h30F0, 8'h20, 8'h00);
    chk(busy, "R11", "busy during op", busy, 1);
    mode = 4'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    begin
      bit dn, er; int rd; logic [15:0] e, pn; logic [7:0] o;
      logic [15:0] xe = {mb(16'h30F1), mb(16'h30F0)} + 16'h0020;
      collect(dn, er, rd, e, o, pn);
      chk(dn, "R11", "busy start done", dn, 1);
      chk(e == xe, "R11", "busy start ea", e, xe);
      chk(pn == 16'h30F2, "R11", "busy start pc", pn, 16'h30F2);
    end
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(!done && !busy, "R11", "no extra result", {done, busy}, 2'b00);
    end

    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

endmodule